// File: doc/BRIEF.md
# DS3 Alarm Indication Signal Serial Generator

This block produces an unbroken serial DS3 alarm indication signal, one bit for each clock on which `en` is high. It walks the complete multiframe layout of 4760 bits: seven subframes, each made of eight blocks of 85 bits. Every block opens with one overhead bit and then carries 84 payload bits.

The first block of each subframe opens with that subframe's lead overhead bit. The seven lead bits are, in subframe order, 1, 1, 0, 0, 0, 1, 0. The other seven blocks open with the framing and stuffing-control bits, which have fixed alarm values. Each payload field carries a 1,0,1,0… pattern, and that pattern starts again with a 1 directly after every overhead bit.

Beside the serial bit, the block drives two markers. One shows that the current bit is an overhead bit. The other shows that the current bit is the first bit of a multiframe. A line interface or test-pattern mux takes the serial bit straight from `ser_o`. Holding `en` low stalls the sequence at its current place in the frame.

Top module: `ais_mframe_gen`

## Requirements
- R1: After a synchronous reset the generator sits at the first bit of a multiframe. That bit is 1 and is driven on `ser_o` whether `en` is high or low.
- R2: `mframe_start_o` is high on exactly one enabled clock in every 4760 enabled clocks. That clock is the one that carries the first bit of the multiframe.
- R3: The lead overhead bits of subframes 1 to 7 have the values 1, 1, 0, 0, 0, 1, 0 in that order. The lead bit sits at bit 0 of the subframe.
- R4: Blocks 2 to 8 of every subframe open with overhead bits of value 1, 0, 0, 0, 0, 0, 1. These are the four framing bits interleaved with three stuffing-control bits. Each of these overhead bits sits at offset 0 of its 85-bit block.
- R5: `ovh_o` is high exactly on enabled clocks whose bit sits at offset 0 of an 85-bit block, and is low on every other clock.
- R6: The 84 payload bits that follow each overhead bit are 1,0,1,0,…,0. The payload restarts with 1 after every overhead bit.
- R7: While `en` is low the position in the frame does not change and both markers are low. When `en` goes high again, the sequence carries on from the bit that was held.
- R8: Asserting `rst` in the middle of a frame returns the generator to the first bit of the multiframe on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable; one bit is sent per enabled clock |
| ser_o | output | 1 | Serial alarm signal bit for the current position |
| ovh_o | output | 1 | Current enabled bit is an overhead bit |
| mframe_start_o | output | 1 | Current enabled bit is the first bit of a multiframe |

## Verification
All three outputs are combinational decodes of the position registers and `en`, so each output is valid in the same cycle as the position and enable that produce it. The position itself moves one step at each rising edge where `en` is high, and the new bit is visible straight after that edge. The bench drives `rst` and `en` on the falling edge and compares all outputs 1 ns later against a model that keeps a single integer bit index. It advances that model index at the following rising edge. A reset therefore shows its effect at the first falling-edge sample after the edge on which `rst` was high.

// File: rtl/ais_pkg.sv
package ais_pkg;

  localparam int PAT_W = 16;

  // Overhead value for a subframe's lead bit, indexed by subframe.
  function automatic logic lead_bit(input logic [PAT_W-1:0] pat, input int sf);
    return pat[sf[3:0]];
  endfunction

  // Overhead value opening block blk (blk >= 1) of any subframe.
  function automatic logic block_ovh_bit(input logic [PAT_W-1:0] pat, input int blk);
    return pat[blk[3:0]];
  endfunction

  // Payload bit at offset k (k >= 1) inside a block: odd offsets carry 1.
  function automatic logic payload_bit(input int k);
    return k[0];
  endfunction

endpackage

// File: rtl/ais_pos_counter.sv
module ais_pos_counter #(
  parameter int SUBFRAMES  = 7,
  parameter int BLOCKS     = 8,
  parameter int BLOCK_BITS = 85,
  localparam int SF_W  = $clog2(SUBFRAMES),
  localparam int BLK_W = $clog2(BLOCKS),
  localparam int BIT_W = $clog2(BLOCK_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  output logic [SF_W-1:0]  sf_idx,
  output logic [BLK_W-1:0] blk_idx,
  output logic [BIT_W-1:0] bit_idx,
  output logic             at_ovh,
  output logic             at_start,
  output logic             at_last
);

  localparam logic [SF_W-1:0]  SF_LAST  = SF_W'(SUBFRAMES - 1);
  localparam logic [BLK_W-1:0] BLK_LAST = BLK_W'(BLOCKS - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BLOCK_BITS - 1);

  logic bit_wrap, blk_wrap, sf_wrap;

  assign bit_wrap = (bit_idx == BIT_LAST);
  assign blk_wrap = bit_wrap && (blk_idx == BLK_LAST);
  assign sf_wrap  = blk_wrap && (sf_idx == SF_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      sf_idx  <= '0;
      blk_idx <= '0;
      bit_idx <= '0;
    end else if (en) begin
      if (bit_wrap) begin
        bit_idx <= '0;
        if (blk_wrap) begin
          blk_idx <= '0;
          sf_idx  <= sf_wrap ? '0 : sf_idx + 1'b1;
        end else begin
          blk_idx <= blk_idx + 1'b1;
        end
      end else begin
        bit_idx <= bit_idx + 1'b1;
      end
    end
  end

  assign at_ovh   = (bit_idx == '0);
  assign at_start = at_ovh && (blk_idx == '0) && (sf_idx == '0);
  assign at_last  = sf_wrap;

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable({sf_idx, blk_idx, bit_idx})); // R7

  AST_BIT_STEP: assert property (@(posedge clk) disable iff (rst)
    (en && !bit_wrap) |=> (bit_idx == $past(bit_idx) + 1'b1)); // R5

  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
    (en && at_last) |=> at_start); // R2

  AST_RESET_TO_START: assert property (@(posedge clk)
    rst |=> at_start); // R8

endmodule

// File: rtl/ais_bit_select.sv
module ais_bit_select
  import ais_pkg::*;
#(
  parameter int SF_W  = 3,
  parameter int BLK_W = 3,
  parameter int BIT_W = 7,
  parameter logic [PAT_W-1:0] LEAD_PATTERN  = 16'h0023,
  parameter logic [PAT_W-1:0] BLOCK_PATTERN = 16'h0082
) (
  input  logic [SF_W-1:0]  sf_idx,
  input  logic [BLK_W-1:0] blk_idx,
  input  logic [BIT_W-1:0] bit_idx,
  output logic             bit_val
);

  logic ovh_val;

  always_comb begin
    if (blk_idx == '0) ovh_val = lead_bit(LEAD_PATTERN, int'(sf_idx));
    else               ovh_val = block_ovh_bit(BLOCK_PATTERN, int'(blk_idx));
  end

  assign bit_val = (bit_idx == '0) ? ovh_val : payload_bit(int'(bit_idx));

endmodule

// File: rtl/ais_mframe_gen.sv
module ais_mframe_gen
  import ais_pkg::*;
#(
  parameter int SUBFRAMES  = 7,
  parameter int BLOCKS     = 8,
  parameter int BLOCK_BITS = 85,
  parameter logic [PAT_W-1:0] LEAD_PATTERN  = 16'h0023,
  parameter logic [PAT_W-1:0] BLOCK_PATTERN = 16'h0082
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic ser_o,
  output logic ovh_o,
  output logic mframe_start_o
);

  localparam int SF_W  = $clog2(SUBFRAMES);
  localparam int BLK_W = $clog2(BLOCKS);
  localparam int BIT_W = $clog2(BLOCK_BITS);

  logic [SF_W-1:0]  sf_idx;
  logic [BLK_W-1:0] blk_idx;
  logic [BIT_W-1:0] bit_idx;
  logic             at_ovh, at_start, at_last;
  logic             pay_last;

  ais_pos_counter #(
    .SUBFRAMES (SUBFRAMES),
    .BLOCKS    (BLOCKS),
    .BLOCK_BITS(BLOCK_BITS)
  ) pos_i (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .sf_idx  (sf_idx),
    .blk_idx (blk_idx),
    .bit_idx (bit_idx),
    .at_ovh  (at_ovh),
    .at_start(at_start),
    .at_last (at_last)
  );

  ais_bit_select #(
    .SF_W         (SF_W),
    .BLK_W        (BLK_W),
    .BIT_W        (BIT_W),
    .LEAD_PATTERN (LEAD_PATTERN),
    .BLOCK_PATTERN(BLOCK_PATTERN)
  ) sel_i (
    .sf_idx (sf_idx),
    .blk_idx(blk_idx),
    .bit_idx(bit_idx),
    .bit_val(ser_o)
  );

  assign pay_last       = (bit_idx == BIT_W'(BLOCK_BITS - 1));
  assign ovh_o          = en && at_ovh;
  assign mframe_start_o = en && at_start;

  AST_START_IS_OVH: assert property (@(posedge clk) disable iff (rst)
    mframe_start_o |-> ovh_o); // R1

  AST_PAYLOAD_OPENS_HIGH: assert property (@(posedge clk) disable iff (rst)
    (en && at_ovh) |=> ser_o); // R6

  AST_PAYLOAD_TOGGLES: assert property (@(posedge clk) disable iff (rst)
    (en && !at_ovh && !pay_last) |=> (ser_o != $past(ser_o))); // R6

  AST_LAST_BEFORE_START: assert property (@(posedge clk) disable iff (rst)
    (en && at_last) |-> (!ser_o && !ovh_o)); // R6

endmodule

// File: tb/ais_mframe_gen_tb_top.sv
module ais_mframe_gen_tb_top;

  localparam int FRAME = 4760;
  localparam int SUBF  = 680;
  localparam int BLK   = 85;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic ser_o, ovh_o, mframe_start_o;

  int checks = 0;
  int errors = 0;
  int pos    = 0;
  bit after_reset = 1'b0;
  bit done = 1'b0;

  int lead_tab [7] = '{1, 1, 0, 0, 0, 1, 0};
  int blk_tab  [8] = '{0, 1, 0, 0, 0, 0, 0, 1};

  always #2.5 clk = ~clk;

  ais_mframe_gen dut_i (
    .clk           (clk),
    .rst           (rst),
    .en            (en),
    .ser_o         (ser_o),
    .ovh_o         (ovh_o),
    .mframe_start_o(mframe_start_o)
  );

  function automatic int exp_bit(input int p);
    int sf = p / SUBF;
    int rem = p % SUBF;
    int b = rem / BLK;
    int k = rem % BLK;
    if (k == 0) return (b == 0) ? lead_tab[sf] : blk_tab[b];
    return (k % 2 == 1) ? 1 : 0;
  endfunction

  task automatic check1(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at pos %0d: actual %b expected %b", tag, what, pos, act, exp);
    end
  endtask

  task automatic step(input logic en_v, input logic rst_v);
    string tag;
    int rem;
    @(negedge clk);
    rst = rst_v;
    en  = en_v;
    #1;
    if (!rst_v) begin
      rem = pos % SUBF;
      if (!en_v)                       tag = "R7";
      else if (pos == 0)               tag = after_reset ? "R8" : "R1";
      else if (rem % BLK != 0)         tag = "R6";
      else if (rem == 0)               tag = "R3";
      else                             tag = "R4";
      check1(tag, ser_o, exp_bit(pos) != 0, "ser_o");
      check1((en_v == 0) ? "R7" : "R5", ovh_o, en_v && (pos % BLK == 0), "ovh_o");
      check1((en_v == 0) ? "R7" : "R2", mframe_start_o, en_v && (pos == 0), "mframe_start_o");
      after_reset = 1'b0;
    end
    @(posedge clk);
    if (rst_v) begin
      pos = 0;
      after_reset = 1'b1;
    end else if (en_v) begin
      pos = (pos + 1) % FRAME;
    end
  endtask

  initial begin
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1);
    // R1: reset state with enable low, then one full frame and a bit more (R2..R6)
    step(1'b0, 1'b0);
    for (int i = 0; i < FRAME + 200; i++) step(1'b1, 1'b0);
    // R7: stall pattern, enable low two of every five clocks
    for (int i = 0; i < 2500; i++) step((i % 5) < 3, 1'b0);
    // R8: reset mid-frame, then a further full frame with sparse stalls
    step(1'b1, 1'b1);
    for (int i = 0; i < FRAME + 300; i++) step((i % 97) != 0, 1'b0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule